// File: doc/BRIEF.md
# Core-Side Stream Port

This block sits between a compute core and the switching fabric of a tile. It holds one word of storage for each inbound stream and one for each outbound stream. A valid flag belongs to each word, and that flag is the only synchronisation between the core and the network. The fabric fills inbound words, and the core takes them. The core fills outbound words, and the fabric drains them. Two status vectors show every valid flag directly, so the core can poll them to learn which streams are ready.

Every storage word is a two-state machine. The states are `SLOT_EMPTY` and `SLOT_FULL`. There are two transitions. Transition `T_FILL` moves a word from `SLOT_EMPTY` to `SLOT_FULL` when a fill request selects it. Transition `T_TAKE` moves a word from `SLOT_FULL` to `SLOT_EMPTY` when a take request selects it. A fill that selects a full word and a take that selects an empty word cause no transition. Each side selects a word by a binary index. A decoder turns that index into a one-hot request. A selector returns the chosen word, and a gate keeps that word at zero unless the access succeeds.

The core may run slower than the fabric. Its accesses count only in cycles where the core enable is high. Everything runs on one clock.

Top module: `stream_port`

## Requirements
- R1: During reset and right after it, both status vectors read 0000 and all response flags are low.
- R2: A fabric write to an empty inbound word (index on `net_wr_sel`) stores the data and sets that word's bit in `in_ind` (bit i = word i) at the next clock edge.
- R3: A fabric write to an inbound word that is already full is ignored: a later core read returns the original data.
- R4: A core read of a full inbound word raises `core_rd_ok` and shows the word on `core_rd_data` in the same cycle, and the word's bit in `in_ind` is clear after the edge.
- R5: A core read of an empty inbound word raises `core_rd_nrdy`, keeps `core_rd_ok` low and leaves `in_ind` unchanged.
- R6: A core write to an empty outbound word raises `core_wr_ok` in the same cycle and sets that word's bit in `out_ind` (bit i = word i) at the next edge.
- R7: A core write to a full outbound word raises `core_wr_busy`, keeps `core_wr_ok` low and leaves the stored word unchanged.
- R8: A fabric drain of a full outbound word raises `net_rd_valid` with the word on `net_rd_data` and clears its `out_ind` bit at the edge. A drain of an empty word keeps `net_rd_valid` low and changes nothing.
- R9: While `core_ce` is low, core read and write requests have no effect, and all four core response flags stay low.
- R10: Accesses to different words in the same cycle are independent, and each one updates only its own status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| net_wr_en | input | 1 | Fabric writes an inbound word |
| net_wr_sel | input | 2 | Inbound word index for fabric write |
| net_wr_data | input | 32 | Fabric write data |
| net_rd_en | input | 1 | Fabric drains an outbound word |
| net_rd_sel | input | 2 | Outbound word index for drain |
| net_rd_data | output | 32 | Drained word (zero unless valid) |
| net_rd_valid | output | 1 | Drain succeeded this cycle |
| core_ce | input | 1 | Core-side cycle enable |
| core_rd_en | input | 1 | Core reads an inbound word |
| core_rd_sel | input | 2 | Inbound word index for core read |
| core_rd_data | output | 32 | Word read by the core (zero unless ok) |
| core_rd_ok | output | 1 | Core read succeeded |
| core_rd_nrdy | output | 1 | Core read found the word empty |
| core_wr_en | input | 1 | Core writes an outbound word |
| core_wr_sel | input | 2 | Outbound word index for core write |
| core_wr_data | input | 32 | Core write data |
| core_wr_ok | output | 1 | Core write accepted |
| core_wr_busy | output | 1 | Core write refused, word still full |
| in_ind | output | 4 | Valid flags of the inbound words |
| out_ind | output | 4 | Valid flags of the outbound words |

## Verification
The assertions check these rules on every cycle: how each flag behaves when a word is filled or taken, that a busy flag appears only over a full outbound word, and that the core response flags stay quiet while the core enable is low. Other behaviour shows only through the bench's scenarios. These are the data that survive a refused write, the exact value read back, and independent accesses made in the same cycle. In those scenarios the bench writes data and then reads it back through the opposite side.

// File: rtl/sp_pkg.sv
package sp_pkg;

    // Occupancy state of one single-word stream buffer
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;

endpackage

// File: rtl/sp_dec.sv
// Binary index to one-hot request, qualified by an enable
module sp_dec #(
    parameter int N  = 4,
    parameter int SW = $clog2(N)
) (
    input  logic          en,
    input  logic [SW-1:0] sel,
    output logic [N-1:0]  onehot
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign onehot[i] = en && (sel == SW'(i));
    end

endmodule

// File: rtl/sp_slot.sv
// One stream word with its valid flag, modelled as a two-state machine
module sp_slot
    import sp_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fill_req,
    input  logic [DW-1:0] fill_data,
    input  logic          take_req,
    output logic          full,
    output logic          fill_ok,
    output logic          take_ok,
    output logic [DW-1:0] word
);

    slot_state_e state, state_nxt;
    logic [DW-1:0] word_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SLOT_EMPTY;
        else        state <= state_nxt;
    end

    // Data register, loaded only on an accepted fill
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       word_q <= '0;
        else if (fill_ok) word_q <= fill_data;
    end

    // Transitions and outputs
    always_comb begin
        state_nxt = state;
        fill_ok   = 1'b0;
        take_ok   = 1'b0;
        full      = 1'b0;
        unique case (state)
            SLOT_EMPTY: begin
                if (fill_req) begin          // T_FILL
                    fill_ok   = 1'b1;
                    state_nxt = SLOT_FULL;
                end
            end
            SLOT_FULL: begin
                full = 1'b1;
                if (take_req) begin          // T_TAKE
                    take_ok   = 1'b1;
                    state_nxt = SLOT_EMPTY;
                end
            end
            default: state_nxt = SLOT_EMPTY;
        endcase
    end

    assign word = word_q;

endmodule

// File: rtl/sp_rdmux.sv
// Selects one stored word and forces zero unless the access succeeded
module sp_rdmux #(
    parameter int N  = 4,
    parameter int DW = 32,
    parameter int SW = $clog2(N)
) (
    input  logic [N-1:0][DW-1:0] words,
    input  logic [SW-1:0]        sel,
    input  logic                 hit,
    output logic [DW-1:0]        q
);

    always_comb begin
        q = '0;
        if (hit) q = words[sel];
    end

endmodule

// File: rtl/stream_port.sv
module stream_port #(
    parameter int N_IN   = 4,
    parameter int N_OUT  = 4,
    parameter int DW     = 32,
    localparam int IN_SW  = $clog2(N_IN),
    localparam int OUT_SW = $clog2(N_OUT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              net_wr_en,
    input  logic [IN_SW-1:0]  net_wr_sel,
    input  logic [DW-1:0]     net_wr_data,
    input  logic              net_rd_en,
    input  logic [OUT_SW-1:0] net_rd_sel,
    output logic [DW-1:0]     net_rd_data,
    output logic              net_rd_valid,
    input  logic              core_ce,
    input  logic              core_rd_en,
    input  logic [IN_SW-1:0]  core_rd_sel,
    output logic [DW-1:0]     core_rd_data,
    output logic              core_rd_ok,
    output logic              core_rd_nrdy,
    input  logic              core_wr_en,
    input  logic [OUT_SW-1:0] core_wr_sel,
    input  logic [DW-1:0]     core_wr_data,
    output logic              core_wr_ok,
    output logic              core_wr_busy,
    output logic [N_IN-1:0]   in_ind,
    output logic [N_OUT-1:0]  out_ind
);

    logic core_rd_req, core_wr_req;
    assign core_rd_req = core_ce && core_rd_en;
    assign core_wr_req = core_ce && core_wr_en;

    // Inbound side: fabric fills, core takes
    logic [N_IN-1:0]          in_fill, in_take, in_fill_ok, in_take_ok;
    logic [N_IN-1:0][DW-1:0]  in_words;

    sp_dec #(.N(N_IN)) u_in_fill_dec (.en(net_wr_en),   .sel(net_wr_sel),  .onehot(in_fill));
    sp_dec #(.N(N_IN)) u_in_take_dec (.en(core_rd_req), .sel(core_rd_sel), .onehot(in_take));

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        sp_slot #(.DW(DW)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .fill_req  (in_fill[i]),
            .fill_data (net_wr_data),
            .take_req  (in_take[i]),
            .full      (in_ind[i]),
            .fill_ok   (in_fill_ok[i]),
            .take_ok   (in_take_ok[i]),
            .word      (in_words[i])
        );
    end

    assign core_rd_ok   = |in_take_ok;
    assign core_rd_nrdy = core_rd_req && !core_rd_ok;

    sp_rdmux #(.N(N_IN), .DW(DW)) u_in_mux (
        .words (in_words),
        .sel   (core_rd_sel),
        .hit   (core_rd_ok),
        .q     (core_rd_data)
    );

    // Outbound side: core fills, fabric drains
    logic [N_OUT-1:0]         out_fill, out_take, out_fill_ok, out_take_ok;
    logic [N_OUT-1:0][DW-1:0] out_words;

    sp_dec #(.N(N_OUT)) u_out_fill_dec (.en(core_wr_req), .sel(core_wr_sel), .onehot(out_fill));
    sp_dec #(.N(N_OUT)) u_out_take_dec (.en(net_rd_en),   .sel(net_rd_sel),  .onehot(out_take));

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        sp_slot #(.DW(DW)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .fill_req  (out_fill[j]),
            .fill_data (core_wr_data),
            .take_req  (out_take[j]),
            .full      (out_ind[j]),
            .fill_ok   (out_fill_ok[j]),
            .take_ok   (out_take_ok[j]),
            .word      (out_words[j])
        );
    end

    assign core_wr_ok   = |out_fill_ok;
    assign core_wr_busy = core_wr_req && !core_wr_ok;
    assign net_rd_valid = |out_take_ok;

    sp_rdmux #(.N(N_OUT), .DW(DW)) u_out_mux (
        .words (out_words),
        .sel   (net_rd_sel),
        .hit   (net_rd_valid),
        .q     (net_rd_data)
    );

endmodule

// File: rtl/sp_chk.sv
module sp_chk #(
    parameter int N_IN   = 4,
    parameter int N_OUT  = 4,
    localparam int IN_SW  = $clog2(N_IN),
    localparam int OUT_SW = $clog2(N_OUT)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              net_wr_en,
    input logic [IN_SW-1:0]  net_wr_sel,
    input logic              net_rd_sel_dummy,
    input logic [OUT_SW-1:0] net_rd_sel,
    input logic              net_rd_valid,
    input logic              core_ce,
    input logic [IN_SW-1:0]  core_rd_sel,
    input logic              core_rd_ok,
    input logic              core_rd_nrdy,
    input logic [OUT_SW-1:0] core_wr_sel,
    input logic              core_wr_ok,
    input logic              core_wr_busy,
    input logic [N_IN-1:0]   in_ind,
    input logic [N_OUT-1:0]  out_ind
);

    logic unused_ok;
    assign unused_ok = net_rd_sel_dummy;

    // R2
    fill_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (net_wr_en && !in_ind[net_wr_sel]) |=> in_ind[$past(net_wr_sel)]);

    // R4
    take_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_rd_ok |=> !in_ind[$past(core_rd_sel)]);

    // R5
    read_flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_rd_ok && core_rd_nrdy));

    // R6
    accept_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_wr_ok |=> out_ind[$past(core_wr_sel)]);

    // R7
    busy_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_wr_busy |-> out_ind[core_wr_sel]);

    // R8
    drain_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        net_rd_valid |=> !out_ind[$past(net_rd_sel)]);

    // R8
    drain_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        net_rd_valid |-> out_ind[net_rd_sel]);

    // R9
    core_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_ce |-> !(core_rd_ok || core_rd_nrdy || core_wr_ok || core_wr_busy));

endmodule

bind stream_port sp_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .net_wr_en        (net_wr_en),
    .net_wr_sel       (net_wr_sel),
    .net_rd_sel_dummy (net_rd_en),
    .net_rd_sel       (net_rd_sel),
    .net_rd_valid     (net_rd_valid),
    .core_ce          (core_ce),
    .core_rd_sel      (core_rd_sel),
    .core_rd_ok       (core_rd_ok),
    .core_rd_nrdy     (core_rd_nrdy),
    .core_wr_sel      (core_wr_sel),
    .core_wr_ok       (core_wr_ok),
    .core_wr_busy     (core_wr_busy),
    .in_ind           (in_ind),
    .out_ind          (out_ind)
);

// File: tb/sim_stream_port.sv
module sim_stream_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        net_wr_en = 0, net_rd_en = 0, core_ce = 0, core_rd_en = 0, core_wr_en = 0;
    logic [1:0]  net_wr_sel = 0, net_rd_sel = 0, core_rd_sel = 0, core_wr_sel = 0;
    logic [31:0] net_wr_data = 0, core_wr_data = 0;
    logic [31:0] net_rd_data, core_rd_data;
    logic        net_rd_valid, core_rd_ok, core_rd_nrdy, core_wr_ok, core_wr_busy;
    logic [3:0]  in_ind, out_ind;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    stream_port u0 (.*);

    task automatic chk(input bit pass, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!pass) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Vector: op[44:43] sel[42:41] data[40:9] flag[8] exp_in[7:4] exp_out[3:0]
    // op: 0 fabric write inbound, 1 core read, 2 core write, 3 fabric drain
    localparam int NV = 14;
    localparam logic [44:0] VEC [NV] = '{
        {2'd0, 2'd0, 32'hA1A1_0001, 1'b1, 4'b0001, 4'b0000},  // R2
        {2'd0, 2'd2, 32'hA2A2_0002, 1'b1, 4'b0101, 4'b0000},  // R2
        {2'd0, 2'd0, 32'hBAD0_BAD0, 1'b0, 4'b0101, 4'b0000},  // R3 ignored
        {2'd1, 2'd0, 32'hA1A1_0001, 1'b1, 4'b0100, 4'b0000},  // R4, R3 data kept
        {2'd1, 2'd0, 32'h0000_0000, 1'b0, 4'b0100, 4'b0000},  // R5
        {2'd1, 2'd2, 32'hA2A2_0002, 1'b1, 4'b0000, 4'b0000},  // R4
        {2'd2, 2'd1, 32'hC1C1_0011, 1'b1, 4'b0000, 4'b0010},  // R6
        {2'd2, 2'd1, 32'hC9C9_0099, 1'b0, 4'b0000, 4'b0010},  // R7 busy
        {2'd2, 2'd3, 32'hC3C3_0033, 1'b1, 4'b0000, 4'b1010},  // R6
        {2'd3, 2'd1, 32'hC1C1_0011, 1'b1, 4'b0000, 4'b1000},  // R8, R7 data kept
        {2'd3, 2'd1, 32'h0000_0000, 1'b0, 4'b0000, 4'b1000},  // R8 empty
        {2'd3, 2'd3, 32'hC3C3_0033, 1'b1, 4'b0000, 4'b0000},  // R8
        {2'd0, 2'd3, 32'hD3D3_0303, 1'b1, 4'b1000, 4'b0000},  // R2
        {2'd1, 2'd3, 32'hD3D3_0303, 1'b1, 4'b0000, 4'b0000}   // R4
    };

    task automatic idle();
        net_wr_en = 0; net_rd_en = 0; core_rd_en = 0; core_wr_en = 0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        core_ce = 1;
        @(negedge clk);
        // R1 during reset
        chk(in_ind == 0 && out_ind == 0, "R1 ind in reset", {24'd0, in_ind, out_ind}, 0);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(in_ind == 0 && out_ind == 0, "R1 ind after reset", {24'd0, in_ind, out_ind}, 0);
        chk(!(net_rd_valid | core_rd_ok | core_rd_nrdy | core_wr_ok | core_wr_busy), "R1 flags",
            {27'd0, net_rd_valid, core_rd_ok, core_rd_nrdy, core_wr_ok, core_wr_busy}, 0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [31:0] d;
            logic        f;
            op = VEC[i][44:43];
            d  = VEC[i][40:9];
            f  = VEC[i][8];
            case (op)
                2'd0: begin net_wr_en  = 1; net_wr_sel  = VEC[i][42:41]; net_wr_data  = d; end
                2'd1: begin core_rd_en = 1; core_rd_sel = VEC[i][42:41]; end
                2'd2: begin core_wr_en = 1; core_wr_sel = VEC[i][42:41]; core_wr_data = d; end
                default: begin net_rd_en = 1; net_rd_sel = VEC[i][42:41]; end
            endcase
            #2;
            case (op)
                2'd1: begin
                    chk(core_rd_ok == f && core_rd_nrdy == !f, f ? "R4 read ok" : "R5 not ready",
                        {30'd0, core_rd_ok, core_rd_nrdy}, {30'd0, f, !f});
                    if (f) chk(core_rd_data == d, "R3/R4 read data", core_rd_data, d);
                end
                2'd2: chk(core_wr_ok == f && core_wr_busy == !f, f ? "R6 accept" : "R7 busy",
                          {30'd0, core_wr_ok, core_wr_busy}, {30'd0, f, !f});
                2'd3: begin
                    chk(net_rd_valid == f, "R8 drain flag", {31'd0, net_rd_valid}, {31'd0, f});
                    if (f) chk(net_rd_data == d, "R7/R8 drain data", net_rd_data, d);
                end
                default: ;
            endcase
            @(negedge clk);
            idle();
            chk(in_ind == VEC[i][7:4] && out_ind == VEC[i][3:0], "R2-table indicators",
                {24'd0, in_ind, out_ind}, {24'd0, VEC[i][7:4], VEC[i][3:0]});
        end

        // R9: core enable low blocks core accesses
        net_wr_en = 1; net_wr_sel = 1; net_wr_data = 32'h5151_5151;
        @(negedge clk); idle();
        core_ce = 0; core_rd_en = 1; core_rd_sel = 1; core_wr_en = 1; core_wr_sel = 0; core_wr_data = 32'h7;
        #2;
        chk(!(core_rd_ok | core_rd_nrdy | core_wr_ok | core_wr_busy), "R9 flags low",
            {28'd0, core_rd_ok, core_rd_nrdy, core_wr_ok, core_wr_busy}, 0);
        @(negedge clk); idle(); core_ce = 1;
        chk(in_ind == 4'b0010 && out_ind == 4'b0000, "R9 no state change",
            {24'd0, in_ind, out_ind}, {24'd0, 8'b0010_0000});

        // R10: concurrent accesses on different words
        core_rd_en = 1; core_rd_sel = 1;
        net_wr_en = 1; net_wr_sel = 2; net_wr_data = 32'h6262_6262;
        core_wr_en = 1; core_wr_sel = 0; core_wr_data = 32'h7070_7070;
        #2;
        chk(core_rd_ok && core_rd_data == 32'h5151_5151, "R10 read alongside write", core_rd_data, 32'h5151_5151);
        chk(core_wr_ok, "R10 write alongside read", {31'd0, core_wr_ok}, 1);
        @(negedge clk); idle();
        chk(in_ind == 4'b0100 && out_ind == 4'b0001, "R10 independent bits",
            {24'd0, in_ind, out_ind}, {24'd0, 8'b0100_0001});
        net_rd_en = 1; net_rd_sel = 0;
        #2;
        chk(net_rd_valid && net_rd_data == 32'h7070_7070, "R10 drain data", net_rd_data, 32'h7070_7070);
        @(negedge clk); idle();

        // R1: reset mid-run empties everything
        rst_n = 0;
        #2;
        chk(in_ind == 0 && out_ind == 0, "R1 reset clears", {24'd0, in_ind, out_ind}, 0);
        @(negedge clk); rst_n = 1;
        @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule